// File: doc/BRIEF.md
# Clock Bank Output Control

This block sits between the configuration registers, the strap pins and a clock output bank of five clocks plus one reference clock. It picks whether the frequency-select and spread-enable controls come from the strap pins or from register bits. It decodes a two-bit multiplier code into a choice among supplied multiplied clocks, and it decodes a two-bit spread mode for the downstream modulator. The multiplied clocks (x1, x2, x3, x4 and a quarter-rate clock) are generated elsewhere and arrive as inputs.

Each output has its own gate controller. A gate controller is a two-state machine, `G_OFF` and `G_ON`, clocked on the falling edge of the clock it gates. The register enable is first passed through a synchroniser on that clock's rising edge. The transition `G_OFF -> G_ON` is taken on a falling edge when the synchronised enable is 1. The transition `G_ON -> G_OFF` is taken on a falling edge when it is 0. Because the gate only changes while its clock is low, a register enable change never cuts a pulse short.

The output-enable pin acts on the bank drive controls combinationally, with no clock involved. A lock monitor is a two-state machine, `L_WAIT -> L_LOCKED`. It takes this transition on the first rising input-clock edge at which the lock indication is high. It stays in `L_LOCKED` until reset, and drives an active-low good flag.

Top module: `clkbank_ctrl`

## Requirements
- R1: When `cfg_ctrl[0]` is 1, the multiplier code is {`pin_fs1`,`pin_fs0`} and spread enable is the inverse of `pin_spread_n`. When `cfg_ctrl[0]` is 0, they are `cfg_ctrl[4:3]` and `cfg_ctrl[6]`, and the pins are ignored.
- R2: Outside test mode, multiplier code 00, 01, 10 and 11 makes every enabled bank clock run at 1, 2, 3 and 4 times the input clock.
- R3: When `cfg_ctrl[7]` is 0 (test mode), every enabled bank clock runs at one quarter of the input clock, whatever the multiplier code.
- R4: When enabled, `ref_clk` always runs at the input clock frequency, including in test mode and for every multiplier code.
- R5: When `oe` is low, `bank_drv` is all zeros at once, without any clock edge and whatever the registers hold. When `oe` is high, `bank_drv` is all ones.
- R6: `spread_mode` = {spread enable, `cfg_ctrl[5]`}. The codes are 0 = second-PLL source, 1 = input pass-through, 2 = 1.0 % spread and 3 = 0.5 % spread.
- R7: `cfg_bank[i]` = 1 enables `bank_clk[i]` and `cfg_ref_en` = 1 enables `ref_clk`. An output that is disabled by its register bit is held low.
- R8: A change of an enable bit reaches its output on the first falling edge of that output's clock that follows two rising edges of the same clock. Every high pulse on a gated output lasts a full half period of its source clock.
- R9: `good_n` is 1 after reset. It goes to 0 at the first rising `clk_in` edge with `lock_in` = 1, and stays 0 until the next reset.
- R10: While `rst_n` is low, all gated clocks are low and `good_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; x1 source, reference source, lock monitor clock |
| clk_x2 | input | 1 | Supplied clock at twice the input rate |
| clk_x3 | input | 1 | Supplied clock at three times the input rate |
| clk_x4 | input | 1 | Supplied clock at four times the input rate |
| clk_quarter | input | 1 | Supplied clock at a quarter of the input rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 8 | Control register: [0] pin select, [3] code LSB, [4] code MSB, [5] spread select, [6] spread enable, [7] normal (1) / test (0) |
| cfg_ref_en | input | 1 | Reference output enable register bit |
| cfg_bank | input | 5 | Per-bank-clock enable register bits |
| pin_fs1 | input | 1 | Strap pin, multiplier code MSB |
| pin_fs0 | input | 1 | Strap pin, multiplier code LSB |
| pin_spread_n | input | 1 | Strap pin, active-low spread enable |
| oe | input | 1 | Bank output enable pin (low = high impedance) |
| lock_in | input | 1 | Lock indication from the clock source |
| bank_clk | output | 5 | Gated bank clocks |
| bank_drv | output | 5 | Per-bank-clock driver enable (0 = tri-state) |
| ref_clk | output | 1 | Gated reference clock |
| spread_mode | output | 2 | Decoded spread mode for the modulator |
| good_n | output | 1 | Latched active-low lock flag |

## Verification
The bank frequency is measured by counting rising edges in a window of four input periods. This is done for every multiplier code, once with the code coming from the pins and once from the register. Each time, the unused source holds a conflicting value, so a wrong source choice shows up as a wrong edge count. Test mode is tried against a non-zero code, to show that the quarter-rate clock overrides the code. Alternating enable masks, a disabled reference and an asynchronous `oe` drop separate per-output gating from bank-wide drive control.

A reference model of the spread code, the drive mask and the lock flag is compared on every falling input-clock edge. A separate run toggles an enable at times unrelated to the clock, so that any runt pulse or a missing synchroniser stage can be seen in the pulse widths and in the latency.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

    // Number of selectable bank sources: x1, x2, x3, x4, quarter
    localparam int NUM_SRC   = 5;
    localparam int CODE_W    = 2;
    localparam int SRC_QUART = NUM_SRC - 1;

    // Control register field positions
    localparam int B_PINSEL  = 0;
    localparam int B_CODE_LO = 3;
    localparam int B_CODE_HI = 4;
    localparam int B_SPR_SEL = 5;
    localparam int B_SPR_EN  = 6;
    localparam int B_NORMAL  = 7;

    typedef enum logic [1:0] {
        SPR_PLL2   = 2'b00,
        SPR_BYPASS = 2'b01,
        SPR_WIDE   = 2'b10,
        SPR_NARROW = 2'b11
    } spread_mode_t;

    typedef enum logic {
        G_OFF = 1'b0,
        G_ON  = 1'b1
    } gate_state_t;

    typedef enum logic {
        L_WAIT   = 1'b0,
        L_LOCKED = 1'b1
    } lock_state_t;

endpackage

// File: rtl/clkctl_decode.sv
`timescale 1ns/1ps
module clkctl_decode
    import clkctl_pkg::*;
(
    input  logic [7:0]         cfg_ctrl,
    input  logic               pin_fs1,
    input  logic               pin_fs0,
    input  logic               pin_spread_n,
    output logic [NUM_SRC-1:0] src_sel,
    output spread_mode_t       spread_mode
);

    logic [CODE_W-1:0] code;
    logic              spr_en;
    logic              test_mode;
    logic              unused_cfg;

    // Source of the frequency and spread controls
    always_comb begin
        if (cfg_ctrl[B_PINSEL]) begin
            code   = {pin_fs1, pin_fs0};
            spr_en = ~pin_spread_n;
        end else begin
            code   = cfg_ctrl[B_CODE_HI:B_CODE_LO];
            spr_en = cfg_ctrl[B_SPR_EN];
        end
    end

    assign test_mode  = ~cfg_ctrl[B_NORMAL];
    assign unused_cfg = ^cfg_ctrl[2:1];

    // Multiplier / test decode into a one-hot source select
    always_comb begin
        src_sel = '0;
        if (test_mode) begin
            src_sel[SRC_QUART] = 1'b1;
        end else begin
            unique case (code)
                2'd0:    src_sel[0] = 1'b1;
                2'd1:    src_sel[1] = 1'b1;
                2'd2:    src_sel[2] = 1'b1;
                default: src_sel[3] = 1'b1;
            endcase
        end
    end

    // Spread mode decode
    always_comb begin
        unique case ({spr_en, cfg_ctrl[B_SPR_SEL]})
            2'b00:   spread_mode = SPR_PLL2;
            2'b01:   spread_mode = SPR_BYPASS;
            2'b10:   spread_mode = SPR_WIDE;
            default: spread_mode = SPR_NARROW;
        endcase
    end

    always_comb begin
        if (!$isunknown(src_sel)) begin
            a_r2_sel_onehot: assert ($onehot(src_sel));
        end
    end

endmodule

// File: rtl/clkctl_gate.sv
`timescale 1ns/1ps
module clkctl_gate
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en_req,
    output logic clk_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_sync;
    gate_state_t            state_q;
    gate_state_t            state_d;

    // Enable synchroniser on the rising edge of the gated clock
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge src_clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[s] <= 1'b0;
                end else if (s == 0) begin
                    sync_q[s] <= en_req;
                end else begin
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign en_sync = sync_q[SYNC_STAGES-1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_OFF: if (en_sync)  state_d = G_ON;
            G_ON:  if (!en_sync) state_d = G_OFF;
            default: state_d = G_OFF;
        endcase
    end

    // State register on the falling edge: changes only while the clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= G_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output
    always_comb begin
        unique case (state_q)
            G_ON:    clk_out = src_clk;
            default: clk_out = 1'b0;
        endcase
    end

    a_r8_turn_on: assert property (@(negedge src_clk) disable iff (!rst_n)
        en_sync |=> (state_q == G_ON));
    a_r8_turn_off: assert property (@(negedge src_clk) disable iff (!rst_n)
        !en_sync |=> (state_q == G_OFF));

endmodule

// File: rtl/clkctl_lock.sv
`timescale 1ns/1ps
module clkctl_lock
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic good_n
);

    lock_state_t state_q;
    lock_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_WAIT:   if (lock_in) state_d = L_LOCKED;
            L_LOCKED: state_d = L_LOCKED;
            default:  state_d = L_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            L_LOCKED: good_n = 1'b0;
            default:  good_n = 1'b1;
        endcase
    end

    a_r9_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lock_in |=> !good_n);
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !good_n |=> !good_n);

endmodule

// File: rtl/clkbank_ctrl.sv
`timescale 1ns/1ps
module clkbank_ctrl
    import clkctl_pkg::*;
#(
    parameter int NUM_BANK    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_in,
    input  logic                clk_x2,
    input  logic                clk_x3,
    input  logic                clk_x4,
    input  logic                clk_quarter,
    input  logic                rst_n,
    input  logic [7:0]          cfg_ctrl,
    input  logic                cfg_ref_en,
    input  logic [NUM_BANK-1:0] cfg_bank,
    input  logic                pin_fs1,
    input  logic                pin_fs0,
    input  logic                pin_spread_n,
    input  logic                oe,
    input  logic                lock_in,
    output logic [NUM_BANK-1:0] bank_clk,
    output logic [NUM_BANK-1:0] bank_drv,
    output logic                ref_clk,
    output logic [1:0]          spread_mode,
    output logic                good_n
);

    logic [NUM_SRC-1:0] src_sel;
    logic [NUM_SRC-1:0] src_vec;
    logic               bank_src;
    spread_mode_t       spr_dec;

    clkctl_decode u_decode (
        .cfg_ctrl     (cfg_ctrl),
        .pin_fs1      (pin_fs1),
        .pin_fs0      (pin_fs0),
        .pin_spread_n (pin_spread_n),
        .src_sel      (src_sel),
        .spread_mode  (spr_dec)
    );

    assign spread_mode = spr_dec;

    // Bank source selection among supplied clocks
    assign src_vec = {clk_quarter, clk_x4, clk_x3, clk_x2, clk_in};

    always_comb begin
        bank_src = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel[i]) bank_src = src_vec[i];
        end
    end

    // Per-output glitch-free gating
    generate
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
                .src_clk (bank_src),
                .rst_n   (rst_n),
                .en_req  (cfg_bank[b]),
                .clk_out (bank_clk[b])
            );
        end
    endgenerate

    clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_gate (
        .src_clk (clk_in),
        .rst_n   (rst_n),
        .en_req  (cfg_ref_en),
        .clk_out (ref_clk)
    );

    // Asynchronous bank-wide tri-state control
    assign bank_drv = {NUM_BANK{oe}};

    clkctl_lock u_lock (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .lock_in (lock_in),
        .good_n  (good_n)
    );

endmodule

// File: tb/tb_clkbank_ctrl.sv
`timescale 1ns/1ps
module tb_clkbank_ctrl;

    localparam int CLK_PERIOD = 24;
    localparam int NB = 5;

    logic          clk_in = 0, clk_x2 = 0, clk_x3 = 0, clk_x4 = 0, clk_quarter = 0;
    logic          rst_n = 0;
    logic [7:0]    cfg_ctrl = 8'hA1;
    logic          cfg_ref_en = 1;
    logic [NB-1:0] cfg_bank = '1;
    logic          pin_fs1 = 0, pin_fs0 = 0, pin_spread_n = 1, oe = 1, lock_in = 0;
    logic [NB-1:0] bank_clk, bank_drv;
    logic          ref_clk, good_n;
    logic [1:0]    spread_mode;

    always #(CLK_PERIOD/2)     clk_in = ~clk_in;
    always #(CLK_PERIOD/4)     clk_x2 = ~clk_x2;
    always #(CLK_PERIOD/6)     clk_x3 = ~clk_x3;
    always #(CLK_PERIOD/8)     clk_x4 = ~clk_x4;
    always #(CLK_PERIOD*2)     clk_quarter = ~clk_quarter;

    clkbank_ctrl dut (
        .clk_in(clk_in), .clk_x2(clk_x2), .clk_x3(clk_x3), .clk_x4(clk_x4),
        .clk_quarter(clk_quarter), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
        .cfg_ref_en(cfg_ref_en), .cfg_bank(cfg_bank), .pin_fs1(pin_fs1),
        .pin_fs0(pin_fs0), .pin_spread_n(pin_spread_n), .oe(oe), .lock_in(lock_in),
        .bank_clk(bank_clk), .bank_drv(bank_drv), .ref_clk(ref_clk),
        .spread_mode(spread_mode), .good_n(good_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, compared on every falling input edge
    logic m_good;
    always @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) m_good <= 1'b1;
        else if (lock_in) m_good <= 1'b0;
    end

    function automatic int exp_spread();
        int en;
        en = cfg_ctrl[0] ? int'(!pin_spread_n) : int'(cfg_ctrl[6]);
        return en * 2 + int'(cfg_ctrl[5]);
    endfunction

    function automatic int exp_bank_edges();
        int code;
        if (!cfg_ctrl[7]) return 1;
        code = cfg_ctrl[0] ? int'({pin_fs1, pin_fs0}) : int'(cfg_ctrl[4:3]);
        return 4 * (code + 1);
    endfunction

    always @(negedge clk_in) begin
        if (!finished) begin
            chk("R6", "spread_mode", int'(spread_mode), exp_spread());
            chk("R5", "bank_drv", int'(bank_drv), oe ? 31 : 0);
            chk("R9", "good_n", int'(good_n), int'(m_good));
        end
    end

    int edg[NB];
    int hi[NB];
    int redg, rhi;

    task automatic measure();
        logic [NB-1:0] pb;
        logic pr;
        @(posedge clk_in);
        #0.5;
        for (int i = 0; i < NB; i++) begin edg[i] = 0; hi[i] = 0; end
        redg = 0; rhi = 0;
        pb = bank_clk; pr = ref_clk;
        for (int k = 0; k < CLK_PERIOD * 4; k++) begin
            #1;
            for (int i = 0; i < NB; i++) begin
                if (bank_clk[i] && !pb[i]) edg[i]++;
                if (bank_clk[i]) hi[i]++;
            end
            if (ref_clk && !pr) redg++;
            if (ref_clk) rhi++;
            pb = bank_clk; pr = ref_clk;
        end
    endtask

    task automatic settle();
        repeat (40) @(posedge clk_in);
        #1;
    endtask

    task automatic check_outputs(input string req);
        measure();
        for (int i = 0; i < NB; i++) begin
            chk(req, $sformatf("bank_clk[%0d] edges", i), edg[i], cfg_bank[i] ? exp_bank_edges() : 0);
            if (!cfg_bank[i]) chk("R7", $sformatf("bank_clk[%0d] held low", i), hi[i], 0);
        end
        chk("R4", "ref_clk edges", redg, cfg_ref_en ? 4 : 0);
        if (!cfg_ref_en) chk("R7", "ref_clk held low", rhi, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int nruns, runts, run;
        bit seen_low;
        // R10: reset state
        repeat (4) @(posedge clk_in);
        #5;
        chk("R10", "bank_clk in reset", int'(bank_clk), 0);
        chk("R10", "ref_clk in reset", int'(ref_clk), 0);
        chk("R10", "good_n in reset", int'(good_n), 1);
        @(posedge clk_in); #1;
        rst_n = 1;
        settle();

        // R1/R2: pins select, register code conflicting (11)
        cfg_ctrl = 8'hB9;
        for (int c = 0; c < 4; c++) begin
            {pin_fs1, pin_fs0} = 2'(c);
            settle();
            check_outputs("R2");
        end
        // R1/R2: register select, pins conflicting (11)
        {pin_fs1, pin_fs0} = 2'b11;
        for (int c = 0; c < 4; c++) begin
            cfg_ctrl = 8'hA0 | 8'(c << 3);
            settle();
            check_outputs("R1");
        end

        // R6/R1: spread from pin and from register, both select values
        cfg_ctrl = 8'h81; pin_spread_n = 0;
        settle(); chk("R6", "spread pin on sel0", int'(spread_mode), 2);
        cfg_ctrl = 8'hA1;
        settle(); chk("R6", "spread pin on sel1", int'(spread_mode), 3);
        cfg_ctrl = 8'h20;
        settle(); chk("R1", "pin ignored in reg mode", int'(spread_mode), 1);
        cfg_ctrl = 8'hC0; pin_spread_n = 1;
        settle(); chk("R1", "spread reg bit", int'(spread_mode), 2);
        cfg_ctrl = 8'h80;
        settle(); chk("R6", "spread off sel0", int'(spread_mode), 0);

        // R3/R4: test mode with non-zero code
        cfg_ctrl = 8'h39;
        settle();
        check_outputs("R3");

        // R7: alternating mask, reference off
        cfg_ctrl = 8'hA1; {pin_fs1, pin_fs0} = 2'b01;
        cfg_bank = 5'b10101; cfg_ref_en = 0;
        settle(); check_outputs("R7");
        cfg_bank = 5'b01010; cfg_ref_en = 1;
        settle(); check_outputs("R7");

        // R5: asynchronous tri-state
        cfg_bank = '1;
        settle();
        #5; oe = 0; #1;
        chk("R5", "bank_drv async low", int'(bank_drv), 0);
        settle();
        oe = 1; #1;
        chk("R5", "bank_drv async high", int'(bank_drv), 31);

        // R8: latency of an enable change (x1 source)
        {pin_fs1, pin_fs0} = 2'b00;
        settle();
        @(posedge clk_in); #1;
        cfg_bank[1] = 0;
        #(CLK_PERIOD - 1 + CLK_PERIOD/4);
        chk("R8", "still on after 1 edge", int'(bank_clk[1]), 1);
        #(CLK_PERIOD);
        chk("R8", "still on after 2 edges", int'(bank_clk[1]), 1);
        #(CLK_PERIOD);
        chk("R8", "off after falling edge", int'(bank_clk[1]), 0);
        cfg_bank[1] = 1;
        settle();

        // R8: no runt pulses while toggling an enable at unrelated times
        nruns = 0; runts = 0; run = 0; seen_low = 0;
        fork
            begin
                repeat (40) begin #37; cfg_bank[0] = ~cfg_bank[0]; end
            end
            begin
                @(posedge clk_in); #0.5;
                repeat (40 * 37) begin
                    #1;
                    if (bank_clk[0]) run++;
                    else begin
                        if (run > 0 && seen_low) begin
                            nruns++;
                            if (run != CLK_PERIOD/2) runts++;
                        end
                        run = 0;
                        seen_low = 1;
                    end
                end
            end
        join
        chk("R8", "runt pulses", runts, 0);
        chk("R8", "pulses seen", int'(nruns > 0), 1);

        // R9: lock latch
        cfg_bank = '1;
        settle();
        chk("R9", "good_n before lock", int'(good_n), 1);
        lock_in = 1;
        @(posedge clk_in); #1;
        lock_in = 0;
        chk("R9", "good_n after lock", int'(good_n), 0);
        repeat (5) @(posedge clk_in);
        #1;
        chk("R9", "good_n latched", int'(good_n), 0);
        rst_n = 0; #1;
        chk("R9", "good_n cleared by reset", int'(good_n), 1);
        chk("R10", "bank_clk off in reset", int'(bank_clk), 0);
        @(posedge clk_in); #1;
        rst_n = 1;
        settle();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule